// File: doc/BRIEF.md
# Three-Way Set-Dueling Policy Selector

This block picks, for every access to a set-associative cache, which of three fixed replacement and insertion policies the cache should apply. A small number of sets are reserved as samples for each policy. These sample sets always run their own policy. Misses in a policy's sample sets are counted in a saturating counter owned by that policy. All remaining sets are followers. A follower takes whichever policy currently shows the fewest sampled misses.

The cache presents the set index of each access together with a miss flag. One cycle later the block returns the chosen policy number and a flag that says whether the set was a sample. Sample sets are recognised from the set index alone, so no storage per set is needed. When a counter would run past its ceiling, all three counters are halved together. This keeps their relative order and lets the competition keep adapting.

Top module: `policy_duel_selector`

## Requirements
- R1: The index is split into an upper field `index[9:5]` and a lower field `index[4:0]`. The set is a sample of policy k (k = 0, 1, 2) when (upper − lower) mod 32 equals k. Any other set is a follower. `pol_sample` is 1 exactly for sample sets.
- R2: A valid access to a sample set of policy k returns `pol_sel` = k, whatever the counter values are.
- R3: A valid access to a follower set returns the policy whose miss counter holds the smallest value.
- R4: When two or three counters share the smallest value, a follower gets the lowest-numbered of them.
- R5: A valid access with `acc_miss` = 1 to a sample set of policy k adds one to counter k. Hits, misses in follower sets and cycles with `acc_valid` = 0 leave every counter unchanged.
- R6: The result for an access sampled at a clock edge appears after that edge. It is based on the counter values from before the access's own update. A counter update is seen by the access in the next cycle.
- R7: The counters are 10 bits wide and saturate at 1023. A counted miss to a policy whose counter already holds 1023 is not added. Instead, all three counters are replaced by their value shifted right by one.
- R8: A synchronous reset clears all counters. It also drives `pol_valid`, `pol_sel` and `pol_sample` to 0.
- R9: `pol_valid` is 1 in the cycle after an access with `acc_valid` = 1, and 0 after a cycle with `acc_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_index | input | 10 | Set index of the access |
| acc_miss | input | 1 | The access missed in the cache |
| pol_valid | output | 1 | Registered result is valid |
| pol_sel | output | 2 | Policy to apply (0, 1 or 2) |
| pol_sample | output | 1 | The access went to a sample set |

## Verification
The hardest situation to reach is the halving step when the counters are close together. Only there does the shift change which policy wins a follower decision. One example is a tie created by flooring two neighbouring values. The stimulus first drives 601 misses into policy 0's samples and 600 into policy 1's. It then drives policy 2's samples to the 1023 ceiling and sends one more miss. The follower choice should then move from policy 1 back to policy 0. One further miss to policy 0 should move it back again. Before this, short runs of hits, follower misses and idle cycles carrying a miss flag check that nothing else moves the counters.

// File: rtl/pds_pkg.sv
package pds_pkg;
  parameter int unsigned DEF_NUM_POL = 3;
  parameter int unsigned DEF_IDX_W   = 10;
  parameter int unsigned DEF_CNT_W   = 10;

  function automatic int unsigned pol_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pds_set_classify.sv
module pds_set_classify #(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned NUM_POL = 3,
  parameter int unsigned POL_W   = 2
) (
  input  logic [IDX_W-1:0] idx,
  output logic             is_sample,
  output logic [POL_W-1:0] pol_id
);
  localparam int unsigned FLD_W = IDX_W / 2;

  logic [FLD_W-1:0] upper_f;
  logic [FLD_W-1:0] lower_f;
  logic [FLD_W-1:0] gap;

  always_comb begin
    upper_f   = idx[IDX_W-1 -: FLD_W];
    lower_f   = idx[FLD_W-1:0];
    gap       = upper_f - lower_f;
    is_sample = (gap < FLD_W'(NUM_POL));
    pol_id    = POL_W'(gap);
  end
endmodule

// File: rtl/pds_miss_bank.sv
module pds_miss_bank #(
  parameter int unsigned NUM_POL = 3,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned POL_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inc_en,
  input  logic [POL_W-1:0]           inc_id,
  output logic [NUM_POL*CNT_W-1:0]   cnt_flat
);
  logic [CNT_W-1:0] cnt [NUM_POL];
  logic [CNT_W-1:0] target_val;
  logic             halve_all;

  always_comb begin
    target_val = '0;
    for (int k = 0; k < NUM_POL; k++) begin
      if (inc_id == POL_W'(k)) target_val = cnt[k];
    end
    halve_all = inc_en && (target_val == {CNT_W{1'b1}});
  end

  for (genvar g = 0; g < NUM_POL; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[g] <= '0;
      end else if (halve_all) begin
        cnt[g] <= cnt[g] >> 1;
      end else if (inc_en && (inc_id == POL_W'(g))) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt[g];
  end
endmodule

// File: rtl/pds_min_pick.sv
module pds_min_pick #(
  parameter int unsigned NUM_POL = 3,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned POL_W   = 2
) (
  input  logic [NUM_POL*CNT_W-1:0] cnt_flat,
  output logic [POL_W-1:0]         best_id
);
  logic [CNT_W-1:0] best_val;

  always_comb begin
    best_id  = '0;
    best_val = cnt_flat[CNT_W-1:0];
    for (int k = 1; k < NUM_POL; k++) begin
      if (cnt_flat[k*CNT_W +: CNT_W] < best_val) begin
        best_val = cnt_flat[k*CNT_W +: CNT_W];
        best_id  = POL_W'(k);
      end
    end
  end
endmodule

// File: rtl/policy_duel_selector.sv
module policy_duel_selector #(
  parameter int unsigned NUM_POL = pds_pkg::DEF_NUM_POL,
  parameter int unsigned IDX_W   = pds_pkg::DEF_IDX_W,
  parameter int unsigned CNT_W   = pds_pkg::DEF_CNT_W,
  parameter int unsigned POL_W   = pds_pkg::pol_width(NUM_POL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_index,
  input  logic             acc_miss,
  output logic             pol_valid,
  output logic [POL_W-1:0] pol_sel,
  output logic             pol_sample
);
  logic                     is_sample;
  logic [POL_W-1:0]         sample_id;
  logic [POL_W-1:0]         winner_id;
  logic [NUM_POL*CNT_W-1:0] cnt_flat;
  logic                     count_en;

  pds_set_classify #(.IDX_W(IDX_W), .NUM_POL(NUM_POL), .POL_W(POL_W)) u_cls (
    .idx       (acc_index),
    .is_sample (is_sample),
    .pol_id    (sample_id)
  );

  assign count_en = acc_valid && acc_miss && is_sample;

  pds_miss_bank #(.NUM_POL(NUM_POL), .CNT_W(CNT_W), .POL_W(POL_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .inc_en   (count_en),
    .inc_id   (sample_id),
    .cnt_flat (cnt_flat)
  );

  pds_min_pick #(.NUM_POL(NUM_POL), .CNT_W(CNT_W), .POL_W(POL_W)) u_pick (
    .cnt_flat (cnt_flat),
    .best_id  (winner_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_valid  <= 1'b0;
      pol_sel    <= '0;
      pol_sample <= 1'b0;
    end else begin
      pol_valid <= acc_valid;
      if (acc_valid) begin
        pol_sel    <= is_sample ? sample_id : winner_id;
        pol_sample <= is_sample;
      end
    end
  end
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             pol_valid,
  input logic [1:0]       pol_sel,
  input logic             pol_sample,
  input logic [3*CNT_W-1:0] cnt_flat
);
  logic [CNT_W-1:0] c0, c1, c2;
  logic [CNT_W-1:0] p0, p1, p2;
  logic [CNT_W-1:0] sel_prev;

  assign c0 = cnt_flat[0 +: CNT_W];
  assign c1 = cnt_flat[CNT_W +: CNT_W];
  assign c2 = cnt_flat[2*CNT_W +: CNT_W];

  always_ff @(posedge clk) begin
    p0 <= c0;
    p1 <= c1;
    p2 <= c2;
  end

  always_comb begin
    case (pol_sel)
      2'd0:    sel_prev = p0;
      2'd1:    sel_prev = p1;
      default: sel_prev = p2;
    endcase
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> pol_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !pol_valid); // R9
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    pol_valid |-> (pol_sel < 2'd3)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (c0 == p0 || c0 == p0 + 1'b1 || c0 == (p0 >> 1)) &&
    (c1 == p1 || c1 == p1 + 1'b1 || c1 == (p1 >> 1)) &&
    (c2 == p2 || c2 == p2 + 1'b1 || c2 == (p2 >> 1))); // R5
  AST_HALVE_ALL: assert property (@(posedge clk) disable iff (rst)
    (c0 < p0 || c1 < p1 || c2 < p2) |->
    (c0 == (p0 >> 1) && c1 == (p1 >> 1) && c2 == (p2 >> 1))); // R7
  AST_FOLLOW_MIN: assert property (@(posedge clk) disable iff (rst)
    (pol_valid && !pol_sample) |->
    (sel_prev <= p0 && sel_prev <= p1 && sel_prev <= p2)); // R3
  AST_TIE_LOW: assert property (@(posedge clk) disable iff (rst)
    (pol_valid && !pol_sample && pol_sel != 2'd0) |-> (sel_prev < p0)); // R4
endmodule

bind policy_duel_selector pds_checker #(.CNT_W(CNT_W)) u_pds_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .pol_valid  (pol_valid),
  .pol_sel    (pol_sel),
  .pol_sample (pol_sample),
  .cnt_flat   (cnt_flat)
);

// File: tb/tb_policy_duel_selector.sv
`timescale 1ns/1ps
module tb_policy_duel_selector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [9:0] acc_index = '0;
  logic       acc_miss = 1'b0;
  logic       pol_valid;
  logic [1:0] pol_sel;
  logic       pol_sample;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    bit       v;
    bit [1:0] sel;
    bit       smp;
    string    tag;
  } exp_t;
  exp_t sb[$];

  int m [3];
  int lo_seed = 7;

  always #5 clk = ~clk;

  policy_duel_selector dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_index(acc_index),
    .acc_miss(acc_miss), .pol_valid(pol_valid), .pol_sel(pol_sel),
    .pol_sample(pol_sample)
  );

  function automatic int argmin();
    int b = 0;
    for (int k = 1; k < 3; k++) if (m[k] < m[b]) b = k;
    return b;
  endfunction

  // off 0..2 = sample of that policy, 3..31 = follower
  task automatic access(input int off, input bit miss, input bit valid, input string tag);
    exp_t e;
    bit [4:0] lo, hi;
    @(negedge clk);
    lo_seed = (lo_seed * 5 + 3) % 32;
    lo = 5'(lo_seed);
    hi = 5'(lo_seed + off);
    acc_valid = valid;
    acc_miss  = miss;
    acc_index = {hi, lo};
    e.tag = tag;
    e.v   = valid;
    e.smp = valid && (off < 3);
    e.sel = (off < 3) ? 2'(off) : 2'(argmin());
    sb.push_back(e);
    if (valid && miss && off < 3) begin
      if (m[off] == 1023) for (int k = 0; k < 3; k++) m[k] = m[k] >> 1;
      else m[off]++;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.v) begin
        if (!(pol_valid === 1'b1 && pol_sel === e.sel && pol_sample === e.smp)) begin
          errors++;
          $display("FAIL %s: valid=%0b sel=%0d sample=%0b expected valid=1 sel=%0d sample=%0b",
                   e.tag, pol_valid, pol_sel, pol_sample, e.sel, e.smp);
        end
      end else if (pol_valid !== 1'b0) begin
        errors++;
        $display("FAIL %s: valid=%0b expected valid=0", e.tag, pol_valid);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) m[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (pol_valid !== 1'b0 || pol_sel !== 2'd0 || pol_sample !== 1'b0) begin
      errors++;
      $display("FAIL R8: valid=%0b sel=%0d sample=%0b expected 0 0 0",
               pol_valid, pol_sel, pol_sample);
    end

    // R1 R2: each sample class with hits
    for (int k = 0; k < 3; k++) access(k, 1'b0, 1'b1, "R1");
    // R4: all counters zero, followers take policy 0
    for (int f = 3; f < 32; f += 7) access(f, 1'b0, 1'b1, "R4");
    // R5 R6: misses in policy 0 samples, follower right after
    access(0, 1'b1, 1'b1, "R5");
    access(0, 1'b1, 1'b1, "R5");
    access(9, 1'b0, 1'b1, "R6");
    // R3: policy 1 misses, follower moves to policy 2
    for (int i = 0; i < 3; i++) access(1, 1'b1, 1'b1, "R3");
    access(20, 1'b0, 1'b1, "R3");
    // R5: follower misses, sample hits, idle misses do not count
    for (int i = 0; i < 10; i++) access(3 + i, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 5; i++) access(2, 1'b0, 1'b1, "R5");
    for (int i = 0; i < 4; i++) access(2, 1'b1, 1'b0, "R9");
    access(31, 1'b0, 1'b1, "R5");
    // R2: samples keep their own policy with uneven counters
    access(0, 1'b0, 1'b1, "R2");
    access(1, 1'b1, 1'b1, "R2");
    // bring counters to 601 / 600
    while (m[0] < 601) access(0, 1'b1, 1'b1, "R5");
    while (m[1] < 600) access(1, 1'b1, 1'b1, "R5");
    access(17, 1'b0, 1'b1, "R3");
    // R7: policy 2 up to ceiling, then one more
    while (m[2] < 1023) access(2, 1'b1, 1'b1, "R7");
    access(5, 1'b0, 1'b1, "R7");
    access(2, 1'b1, 1'b1, "R7");
    access(6, 1'b0, 1'b1, "R7");
    access(0, 1'b1, 1'b1, "R7");
    access(7, 1'b0, 1'b1, "R4");
    access(2, 1'b0, 1'b1, "R2");
    access(8, 1'b0, 1'b0, "R9");

    @(negedge clk);
    acc_valid = 1'b0;
    acc_miss  = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R6: %0d results outstanding expected 0", sb.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule